// File: doc/BRIEF.md
# Bit-Serial Four-Bit Adder

This block adds two unsigned operands one bit per clock. A two-bit control code selects what happens on each rising edge. The load code copies both operands into two internal shift registers and clears the running carry. The shift code moves both registers one place toward bit 0. The bits that leave at the bottom of each register feed a one-bit full adder. The adder's sum bit enters the top of the operand-A register, so the result builds up in place, and its carry-out is stored in a carry flip-flop. The other codes hold everything.

The surrounding logic issues one load, then four consecutive shift codes. After the fourth shift edge, the sum output holds the operand sum modulo 2^W and the carry output holds the bit that overflowed. The result is not valid before that edge. The control and data pins are plain, level-sampled signals with no handshake. The block always accepts a code, so there is no back-pressure. An active-low reset clears all state at once, without waiting for a clock edge.

Top module: `serial_adder`

## Requirements
- R1: While rst_n is low, sum and carry_out are 0 at once, without waiting for a clock edge.
- R2: A rising edge with mode = 2'b11 loads op_a into the result register and op_b into the operand register, and clears the carry. After that edge, sum equals op_a and carry_out is 0.
- R3: A rising edge with mode = 2'b01 shifts the result register right by one. The new bit W-1 is a XOR b XOR c, where a and b are bit 0 of the two registers and c is the stored carry. The stored carry becomes the majority of a, b and c. The operand register takes a 0 at its top bit.
- R4: After a load and then W consecutive shift edges, sum equals (op_a + op_b) mod 2^W and carry_out equals bit W of op_a + op_b, using the operands that were present at the load edge.
- R5: Code 2'b00 keeps sum, carry_out and the operand register unchanged.
- R6: Code 2'b10 behaves exactly like 2'b00 (hold).
- R7: A load in the middle of a shift sequence discards the partial result and restarts: sum becomes the new op_a and carry_out becomes 0.
- R8: op_a and op_b have no effect on any edge whose code is not 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | First operand, sampled on load |
| op_b | input | W | Second operand, sampled on load |
| mode | input | 2 | 00/10 hold, 11 load, 01 shift right |
| sum | output | W | Result register contents |
| carry_out | output | 1 | Stored carry |

## Verification
A restart and an active accumulation can fall in the same cycle. The bench builds up a carry over two shift edges and then issues a load code. This is a case where a stale carry or partial sum could leak into the new operation. The scoreboard expects sum to equal the fresh op_a with carry 0, and then expects the full new sum after four further shifts. The bench also changes op_a and op_b in the middle of a sequence, and applies reset while a shift is in progress, which tests reset against the clocked update.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
  typedef enum logic [1:0] {
    CTL_HOLD     = 2'b00,
    CTL_SHIFT    = 2'b01,
    CTL_HOLD_ALT = 2'b10,
    CTL_LOAD     = 2'b11
  } ctl_code_e;

  typedef struct packed {
    logic load;
    logic shift;
  } ctl_dec_t;

  function automatic ctl_dec_t decode_ctl(input logic [1:0] code);
    ctl_dec_t d;
    d.load  = (code == CTL_LOAD);
    d.shift = (code == CTL_SHIFT);
    return d;
  endfunction
endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W-1) begin : g_top
      always_comb begin
        if (load)       nxt[i] = par_in[i];
        else if (shift) nxt[i] = ser_in;
        else            nxt[i] = q[i];
      end
    end else begin : g_mid
      always_comb begin
        if (load)       nxt[i] = par_in[i];
        else if (shift) nxt[i] = q[i+1];
        else            nxt[i] = q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/sa_full_adder.sv
module sa_full_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic cout
);
  always_comb begin
    s    = a ^ b ^ cin;
    cout = (a & b) | (a & cin) | (b & cin);
  end
endmodule

// File: rtl/sa_carry_ff.sv
module sa_carry_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/serial_adder.sv
module serial_adder
  import serial_adder_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   mode,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  ctl_dec_t     ctl;
  logic [W-1:0] acc_q;
  logic [W-1:0] opb_q;
  logic         fa_s;
  logic         fa_c;
  logic         cy_q;
  logic         cy_en;
  logic         cy_d;

  assign ctl = decode_ctl(mode);

  sa_shift_reg #(.W(W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ctl.load),
    .shift  (ctl.shift),
    .par_in (op_a),
    .ser_in (fa_s),
    .q      (acc_q)
  );

  sa_shift_reg #(.W(W)) u_opb (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ctl.load),
    .shift  (ctl.shift),
    .par_in (op_b),
    .ser_in (1'b0),
    .q      (opb_q)
  );

  sa_full_adder u_fa (
    .a    (acc_q[0]),
    .b    (opb_q[0]),
    .cin  (cy_q),
    .s    (fa_s),
    .cout (fa_c)
  );

  // load clears the carry, shift captures the adder carry
  always_comb begin
    cy_en = ctl.load | ctl.shift;
    cy_d  = ctl.shift ? fa_c : 1'b0;
  end

  sa_carry_ff u_cy (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cy_en),
    .d     (cy_d),
    .q     (cy_q)
  );

  assign sum       = acc_q;
  assign carry_out = cy_q;
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [1:0]   mode,
  input logic [W-1:0] sum,
  input logic         carry_out
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] n_shift;
  logic          armed;
  logic [W:0]    want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_shift <= '0;
      armed   <= 1'b0;
      want    <= '0;
    end else if (mode == 2'b11) begin
      n_shift <= '0;
      armed   <= 1'b1;
      want    <= {1'b0, op_a} + {1'b0, op_b};
    end else if (mode == 2'b01 && armed) begin
      if (n_shift == CW'(W - 1)) armed <= 1'b0;
      n_shift <= n_shift + 1'b1;
    end
  end

  // R1
  always @(posedge clk)
    if (!rst_n) a_r1_reset_clear: assert (sum == '0 && carry_out == 1'b0);

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> (sum == $past(op_a) && carry_out == 1'b0));

  a_r3_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> sum[W-2:0] == $past(sum[W-1:1]));

  a_r4_final_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && armed && n_shift == CW'(W - 1))
      |=> (sum == want[W-1:0] && carry_out == want[W]));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> ($stable(sum) && $stable(carry_out)));

  a_r6_hold_alt: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> ($stable(sum) && $stable(carry_out)));
endmodule

bind serial_adder serial_adder_chk #(.W(W)) u_chk (.*);

// File: tb/serial_adder_test.sv
module serial_adder_test;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] s;
    logic         c;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] sum;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [W-1:0] m_a, m_b;
  logic         m_c;
  bit           done = 1'b0;

  serial_adder #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .mode(mode), .sum(sum), .carry_out(carry_out)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] es, input logic ec);
    checks++;
    if (sum !== es || carry_out !== ec) begin
      errors++;
      $display("FAIL %s: sum=%0d carry=%0b expected sum=%0d carry=%0b",
               tag, sum, carry_out, es, ec);
    end
  endtask

  // drive one edge, update the reference model, push the expected state
  task automatic step(input logic [1:0] m, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string tag);
    logic s, co;
    exp_t e;
    @(negedge clk);
    mode = m; op_a = a; op_b = b;
    @(posedge clk);
    if (m == 2'b11) begin
      m_a = a; m_b = b; m_c = 1'b0;
    end else if (m == 2'b01) begin
      s   = m_a[0] ^ m_b[0] ^ m_c;
      co  = (m_a[0] & m_b[0]) | (m_a[0] & m_c) | (m_b[0] & m_c);
      m_a = {s, m_a[W-1:1]};
      m_b = {1'b0, m_b[W-1:1]};
      m_c = co;
    end
    e.s = m_a; e.c = m_c; e.tag = tag;
    q.push_back(e);
  endtask

  // R4: independent arithmetic check after a full sequence
  task automatic add_seq(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] tot;
    tot = {1'b0, a} + {1'b0, b};
    step(2'b11, a, b, "R2");
    for (int i = 0; i < W; i++) step(2'b01, a, b, "R3");
    @(negedge clk); #1;
    check("R4", tot[W-1:0], tot[W]);
  endtask

  // monitor: compare scoreboard items away from the active edge
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, e.s, e.c);
    end
  end

  initial begin
    m_a = '0; m_b = '0; m_c = 1'b0;
    #12;
    check("R1", '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    add_seq(4'd3, 4'd5);
    add_seq(4'd15, 4'd1);
    add_seq(4'd9, 4'd12);
    add_seq(4'd15, 4'd15);
    add_seq(4'd0, 4'd0);

    // R5 / R6 holds in the middle of a sequence
    step(2'b11, 4'd7, 4'd11, "R2");
    step(2'b01, 4'd7, 4'd11, "R3");
    step(2'b00, 4'd7, 4'd11, "R5");
    step(2'b10, 4'd7, 4'd11, "R6");
    step(2'b01, 4'd7, 4'd11, "R3");
    // R8: operands change while not loading
    step(2'b01, 4'd0, 4'd15, "R8");
    step(2'b10, 4'd5, 4'd2, "R8");
    step(2'b01, 4'd1, 4'd9, "R8");
    @(negedge clk); #1;
    check("R4", 4'd2, 1'b1); // 7 + 11 = 18

    // R7: reload after two shifts with a pending carry
    step(2'b11, 4'd15, 4'd15, "R2");
    step(2'b01, 4'd15, 4'd15, "R3");
    step(2'b01, 4'd15, 4'd15, "R3");
    step(2'b11, 4'd6, 4'd4, "R7");
    for (int i = 0; i < W; i++) step(2'b01, 4'd6, 4'd4, "R3");
    @(negedge clk); #1;
    check("R7", 4'd10, 1'b0);

    // R1: asynchronous reset in the middle of a shift
    step(2'b11, 4'd13, 4'd9, "R2");
    @(negedge clk);
    mode = 2'b01;
    #2 rst_n = 1'b0;
    #1 check("R1", '0, 1'b0);
    @(negedge clk);
    q.delete();
    m_a = '0; m_b = '0; m_c = 1'b0;
    mode = 2'b00;
    rst_n = 1'b1;
    step(2'b00, 4'd3, 4'd3, "R5");
    add_seq(4'd13, 4'd9);

    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule